// File: doc/BRIEF.md
# Flash Operating-Mode Reset Controller

This block keeps the operating state of an embedded flash array and decides how a reset request is treated in each state. The array sits in read mode until a start strobe launches a program, bulk erase or sector erase. The operation then runs until a done strobe ends it or an error flag stops it in a fault state. Cell timing is not modelled: operations are bounded only by those strobes.

Resets come from two places: a reset command, which is a command strobe carrying code 2'b01, and a level-sensitive hardware reset input. Depending on the current state, a reset is either dropped, applied on the next clock, or applied after a recovery wait. The wait is a fixed number of clocks, derived from a 25 us interval and the clock period. A busy flag covers operations and the recovery wait. A ready flag marks read mode. The fault state is left only through a reset, and arriving back in read mode clears it.

Top module: `flash_mode_ctrl`

## Requirements
- R1: While and after the asynchronous reset `rst_n` is low, the mode is read (code 0), `ready_o` is 1 and `busy_o` is 0. The mode codes are: read 0, program 1, bulk erase 2, sector erase 3, fault 4, recovering 5.
- R2: In read mode a start strobe moves the mode on the next clock to program, bulk erase or sector erase. If several strobes arrive together, program wins over bulk erase, and bulk erase wins over sector erase. Start strobes in any other mode have no effect.
- R3: `op_done_i` in program, bulk erase or sector erase returns the mode to read on the next clock.
- R4: `err_i` during program, bulk erase or sector erase moves the mode to fault, with both flags low. Fault is left only by a reset. Start strobes and `op_done_i` are ignored in fault, and so is `err_i` in read mode.
- R5: A reset command (`cmd_valid_i` with `cmd_code_i` = 2'b01) in read mode keeps read mode and overrides any start strobe in the same cycle. Other command codes have no effect in any mode.
- R6: A reset command in fault enters recovering for exactly `RECOV_CYCLES` clocks, where `RECOV_CYCLES` = 25000 ns divided by the clock period in ns. The mode then becomes read.
- R7: A reset command during program or bulk erase is ignored, and the operation continues.
- R8: A reset command during sector erase aborts it and enters recovering for `RECOV_CYCLES` clocks, then read.
- R9: `hw_rst_i` high in program, bulk erase, sector erase or recovering enters recovering and reloads the full wait. Read follows `RECOV_CYCLES` clocks after the last cycle `hw_rst_i` is high. In read or fault, `hw_rst_i` gives read on the next clock.
- R10: `busy_o` is high exactly in program, bulk erase, sector erase and recovering. `ready_o` is high exactly in read. The two are never high together.
- R11: `hw_rst_i` takes priority over every other input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 2 | Decoded command type, 2'b01 = reset |
| hw_rst_i | input | 1 | Hardware reset level, active high |
| start_prog_i | input | 1 | Start program strobe |
| start_bulk_i | input | 1 | Start bulk erase strobe |
| start_sect_i | input | 1 | Start sector erase strobe |
| op_done_i | input | 1 | Operation finished strobe |
| err_i | input | 1 | Operation error flag |
| mode_o | output | 3 | Current mode code |
| busy_o | output | 1 | Operation or recovery in progress |
| ready_o | output | 1 | Array is in read mode |

## Verification
The assertions assume that all inputs are synchronous to `clk` and hold steady around the sampling edge. They also assume the hardware reset input is free of glitches shorter than one clock. The bench meets this by changing every input on the falling edge and sampling outputs one half period later. The properties on ignored reset commands only demand that the mode holds when no error, done or hardware reset arrives in the same cycle. The bench exercises those combinations separately, so that the priority order is tested on its own.

// File: rtl/flash_mode_pkg.sv
package flash_mode_pkg;
  typedef enum logic [2:0] {
    FM_READ  = 3'd0,
    FM_PROG  = 3'd1,
    FM_BULK  = 3'd2,
    FM_SECT  = 3'd3,
    FM_FAULT = 3'd4,
    FM_RECOV = 3'd5
  } fmode_e;

  localparam logic [1:0] CMD_RESET = 2'b01;
endpackage

// File: rtl/fmc_rst_sync.sv
module fmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shreg <= '0;
    else         shreg <= {shreg[STAGES-2:0], 1'b1};
  end

  assign srst_n = shreg[STAGES-1];
endmodule

// File: rtl/fmc_recov_timer.sv
module fmc_recov_timer #(
  parameter int unsigned CYCLES = 3125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int W = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [W-1:0] RELOAD = W'(CYCLES - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign expired = (cnt_q == '0);
  assign cnt_en  = load | (run & ~expired);

  always_comb begin
    if (load) cnt_d = RELOAD;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fmc_mode_next.sv
module fmc_mode_next
  import flash_mode_pkg::*;
(
  input  fmode_e cur,
  input  logic   sw_rst,
  input  logic   hw_rst,
  input  logic   start_prog,
  input  logic   start_bulk,
  input  logic   start_sect,
  input  logic   op_done,
  input  logic   err,
  input  logic   expired,
  output fmode_e nxt,
  output logic   tmr_load
);
  logic active;

  assign active = (cur == FM_PROG) || (cur == FM_BULK) ||
                  (cur == FM_SECT) || (cur == FM_RECOV);

  always_comb begin
    nxt      = cur;
    tmr_load = 1'b0;
    if (hw_rst) begin
      if (active) begin
        nxt      = FM_RECOV;
        tmr_load = 1'b1;
      end else begin
        nxt = FM_READ;
      end
    end else begin
      unique case (cur)
        FM_READ: begin
          if (sw_rst)          nxt = FM_READ;
          else if (start_prog) nxt = FM_PROG;
          else if (start_bulk) nxt = FM_BULK;
          else if (start_sect) nxt = FM_SECT;
        end
        FM_PROG, FM_BULK: begin
          if (err)          nxt = FM_FAULT;
          else if (op_done) nxt = FM_READ;
        end
        FM_SECT: begin
          if (sw_rst) begin
            nxt      = FM_RECOV;
            tmr_load = 1'b1;
          end else if (err) begin
            nxt = FM_FAULT;
          end else if (op_done) begin
            nxt = FM_READ;
          end
        end
        FM_FAULT: begin
          if (sw_rst) begin
            nxt      = FM_RECOV;
            tmr_load = 1'b1;
          end
        end
        FM_RECOV: begin
          if (expired) nxt = FM_READ;
        end
        default: nxt = FM_READ;
      endcase
    end
  end
endmodule

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl
  import flash_mode_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned RECOV_NS      = 25000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_code_i,
  input  logic       hw_rst_i,
  input  logic       start_prog_i,
  input  logic       start_bulk_i,
  input  logic       start_sect_i,
  input  logic       op_done_i,
  input  logic       err_i,
  output logic [2:0] mode_o,
  output logic       busy_o,
  output logic       ready_o
);
  localparam int unsigned RECOV_CYCLES_RAW = (RECOV_NS * 1000) / CLK_PERIOD_PS;
  localparam int unsigned RECOV_CYCLES = (RECOV_CYCLES_RAW == 0) ? 1 : RECOV_CYCLES_RAW;

  logic   rst_core_n;
  fmode_e mode_q, mode_d;
  logic   mode_en;
  logic   sw_rst, tmr_load, tmr_expired;

  fmc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_core_n)
  );

  assign sw_rst = cmd_valid_i && (cmd_code_i == CMD_RESET);

  fmc_mode_next u_next (
    .cur        (mode_q),
    .sw_rst     (sw_rst),
    .hw_rst     (hw_rst_i),
    .start_prog (start_prog_i),
    .start_bulk (start_bulk_i),
    .start_sect (start_sect_i),
    .op_done    (op_done_i),
    .err        (err_i),
    .expired    (tmr_expired),
    .nxt        (mode_d),
    .tmr_load   (tmr_load)
  );

  fmc_recov_timer #(.CYCLES(RECOV_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .load    (tmr_load),
    .run     (mode_q == FM_RECOV),
    .expired (tmr_expired)
  );

  assign mode_en = (mode_d != mode_q);

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  mode_q <= FM_READ;
    else if (mode_en) mode_q <= mode_d;
  end

  assign mode_o  = mode_q;
  assign ready_o = (mode_q == FM_READ);
  assign busy_o  = (mode_q == FM_PROG) || (mode_q == FM_BULK) ||
                   (mode_q == FM_SECT) || (mode_q == FM_RECOV);
endmodule

// File: rtl/fmc_checker.sv
module fmc_checker
  import flash_mode_pkg::*;
(
  input logic       clk,
  input logic       rst_ok,
  input logic       cmd_valid,
  input logic [1:0] cmd_code,
  input logic       hw_rst,
  input logic       err,
  input logic       op_done,
  input logic [2:0] mode,
  input logic       busy,
  input logic       ready
);
  logic sw;
  logic act;
  assign sw  = cmd_valid && (cmd_code == CMD_RESET);
  assign act = (mode == FM_PROG) || (mode == FM_BULK) ||
               (mode == FM_SECT) || (mode == FM_RECOV);

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    !(busy && ready));

  assert_ready_means_read_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    ready |-> (mode == FM_READ));

  assert_prog_keeps_on_cmd_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode == FM_PROG && sw && !hw_rst && !err && !op_done) |=> (mode == FM_PROG));

  assert_sect_abort_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode == FM_SECT && sw && !hw_rst) |=> (mode == FM_RECOV));

  assert_hw_aborts_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    (hw_rst && act) |=> (mode == FM_RECOV && busy));

  assert_recov_exit_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode == FM_RECOV && !hw_rst) |=> (mode == FM_RECOV || mode == FM_READ));

  assert_fault_holds_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode == FM_FAULT && !hw_rst && !sw) |=> (mode == FM_FAULT && !busy && !ready));

  assert_idle_cmd_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode == FM_READ && sw && !hw_rst) |=> (mode == FM_READ));
endmodule

bind flash_mode_ctrl fmc_checker u_fmc_checker (
  .clk       (clk),
  .rst_ok    (rst_core_n),
  .cmd_valid (cmd_valid_i),
  .cmd_code  (cmd_code_i),
  .hw_rst    (hw_rst_i),
  .err       (err_i),
  .op_done   (op_done_i),
  .mode      (mode_o),
  .busy      (busy_o),
  .ready     (ready_o)
);

// File: tb/sim_flash_mode_ctrl.sv
`timescale 1ns/1ps
module sim_flash_mode_ctrl;
  localparam int N = (25000 * 1000) / 8000;
  localparam logic [2:0] M_READ = 3'd0, M_PROG = 3'd1, M_BULK = 3'd2,
                         M_SECT = 3'd3, M_FAULT = 3'd4, M_RECOV = 3'd5;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, hw, sp, sb, ss, dn, er;
  logic [1:0] code;
  logic [2:0] mode;
  logic busy, ready;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  flash_mode_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_code_i(code),
    .hw_rst_i(hw), .start_prog_i(sp), .start_bulk_i(sb), .start_sect_i(ss),
    .op_done_i(dn), .err_i(er), .mode_o(mode), .busy_o(busy), .ready_o(ready)
  );

  task automatic clear_in();
    cmd_valid = 0; code = 2'b00; hw = 0; sp = 0; sb = 0; ss = 0; dn = 0; er = 0;
  endtask

  // Drive one cycle of inputs from a falling edge; return at the next falling edge.
  task automatic cyc(input logic cv, input logic [1:0] cc, input logic h,
                     input logic p, input logic b, input logic s,
                     input logic d, input logic e);
    cmd_valid = cv; code = cc; hw = h; sp = p; sb = b; ss = s; dn = d; er = e;
    @(posedge clk);
    @(negedge clk);
    clear_in();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 2'b00, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic expect_mode(input string req, input logic [2:0] exp);
    logic eb, er_;
    eb  = (exp == M_PROG) || (exp == M_BULK) || (exp == M_SECT) || (exp == M_RECOV);
    er_ = (exp == M_READ);
    n_chk++;
    if (mode !== exp || busy !== eb || ready !== er_) begin
      n_bad++;
      $display("FAIL %s: mode=%0d busy=%b ready=%b, expected mode=%0d busy=%b ready=%b",
               req, mode, busy, ready, exp, eb, er_);
    end
  endtask

  task automatic t_reset();
    clear_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    expect_mode("R1 during reset", M_READ);
    rst_n = 1;
    idle(3);
    expect_mode("R1 after reset", M_READ);
  endtask

  task automatic t_prog();
    cyc(0, 2'b00, 0, 1, 0, 0, 0, 0);
    expect_mode("R2 start program", M_PROG);
    cyc(1, 2'b01, 0, 0, 0, 0, 0, 0);
    expect_mode("R7 reset cmd ignored in program", M_PROG);
    cyc(0, 2'b00, 0, 0, 1, 1, 0, 0);
    expect_mode("R2 start ignored outside read", M_PROG);
    cyc(0, 2'b00, 0, 0, 0, 0, 1, 0);
    expect_mode("R3 done from program", M_READ);
  endtask

  task automatic t_bulk();
    cyc(0, 2'b00, 0, 0, 1, 1, 0, 0);
    expect_mode("R2 bulk over sector priority", M_BULK);
    cyc(1, 2'b01, 0, 0, 0, 0, 0, 0);
    expect_mode("R7 reset cmd ignored in bulk erase", M_BULK);
    cyc(0, 2'b00, 0, 0, 0, 0, 1, 0);
    expect_mode("R3 done from bulk erase", M_READ);
    cyc(0, 2'b00, 0, 1, 1, 1, 0, 0);
    expect_mode("R2 program over bulk priority", M_PROG);
    cyc(0, 2'b00, 0, 0, 0, 0, 1, 0);
    expect_mode("R3 done after priority start", M_READ);
  endtask

  task automatic t_sect_abort();
    cyc(0, 2'b00, 0, 0, 0, 1, 0, 0);
    expect_mode("R2 start sector erase", M_SECT);
    cyc(1, 2'b01, 0, 0, 0, 0, 0, 0);
    expect_mode("R8 reset cmd aborts sector erase", M_RECOV);
    idle(N - 1);
    expect_mode("R8 still recovering at last wait cycle", M_RECOV);
    idle(1);
    expect_mode("R8 read after full wait", M_READ);
    cyc(0, 2'b00, 0, 0, 0, 1, 0, 0);
    cyc(0, 2'b00, 0, 0, 0, 0, 1, 0);
    expect_mode("R3 done from sector erase", M_READ);
  endtask

  task automatic t_fault();
    cyc(0, 2'b00, 0, 0, 0, 0, 0, 1);
    expect_mode("R4 error ignored in read", M_READ);
    cyc(0, 2'b00, 0, 1, 0, 0, 0, 0);
    cyc(0, 2'b00, 0, 0, 0, 0, 0, 1);
    expect_mode("R4 error enters fault", M_FAULT);
    cyc(0, 2'b00, 0, 1, 1, 1, 1, 0);
    expect_mode("R4 start and done ignored in fault", M_FAULT);
    cyc(1, 2'b10, 0, 0, 0, 0, 0, 0);
    expect_mode("R5 other command code ignored", M_FAULT);
    cyc(1, 2'b01, 0, 0, 0, 0, 0, 0);
    expect_mode("R6 reset cmd in fault starts recovery", M_RECOV);
    idle(N - 1);
    expect_mode("R6 still recovering at last wait cycle", M_RECOV);
    idle(1);
    expect_mode("R6 read after full wait", M_READ);
  endtask

  task automatic t_idle_cmd();
    cyc(1, 2'b01, 0, 1, 0, 0, 0, 0);
    expect_mode("R5 reset cmd in read overrides start", M_READ);
    cyc(1, 2'b11, 0, 0, 0, 0, 0, 0);
    expect_mode("R5 other code in read", M_READ);
  endtask

  task automatic t_hw();
    cyc(0, 2'b00, 0, 0, 1, 0, 0, 0);
    cyc(0, 2'b00, 1, 0, 0, 0, 0, 0);
    expect_mode("R9 hw reset aborts bulk erase", M_RECOV);
    for (int i = 0; i < 9; i++) cyc(0, 2'b00, 1, 0, 0, 0, 0, 0);
    idle(N - 1);
    expect_mode("R9 held hw reset counts from release", M_RECOV);
    idle(1);
    expect_mode("R9 read after held hw reset", M_READ);
    cyc(0, 2'b00, 0, 1, 0, 0, 0, 0);
    cyc(0, 2'b00, 1, 0, 0, 0, 0, 0);
    expect_mode("R9 hw reset aborts program", M_RECOV);
    idle(100);
    cyc(0, 2'b00, 1, 0, 0, 0, 0, 0);
    idle(N - 1);
    expect_mode("R9 hw reset restarts recovery", M_RECOV);
    idle(1);
    expect_mode("R9 read after restarted recovery", M_READ);
    cyc(0, 2'b00, 0, 0, 0, 1, 0, 0);
    cyc(1, 2'b01, 1, 0, 0, 0, 1, 1);
    expect_mode("R11 hw reset beats done and error in sector erase", M_RECOV);
    idle(N);
    expect_mode("R11 read after recovery", M_READ);
    cyc(0, 2'b00, 1, 1, 0, 0, 0, 0);
    expect_mode("R11 hw reset in read beats start", M_READ);
    cyc(0, 2'b00, 0, 0, 1, 0, 0, 0);
    cyc(0, 2'b00, 0, 0, 0, 0, 0, 1);
    expect_mode("R4 error in bulk erase", M_FAULT);
    cyc(0, 2'b00, 1, 0, 0, 0, 0, 0);
    expect_mode("R9 hw reset in fault gives read at once", M_READ);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    clear_in();
    rst_n = 0;
    @(negedge clk);
    t_reset();
    t_prog();
    t_bulk();
    t_sect_abort();
    t_fault();
    t_idle_cmd();
    t_hw();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule